// File: doc/BRIEF.md
# Nibble-Pair Transmit Word Assembler

This block sits at the edge of a transmit datapath. It takes a narrow parallel bus, 6 bits by default, and a sync strobe, and it builds full-width samples for a downstream interpolation filter. In the normal mode, a cycle with sync low captures the first half of a word. The next cycle with sync high supplies the second half and completes the word. A configuration bit sets which half the first nibble fills.

In the reduced-resolution bypass mode, every bus value is a complete word on its own and the sync level plays no part. A gain-mode qualifier marks cycles in which the bus carries gain settings rather than samples. Nothing from those cycles reaches the word path. When sync stays low for several cycles, the last finished word stays on the output and a held flag marks each repeated word slot. Downstream filters can be flushed this way.

All capture happens on the rising clock edge. The outputs are registered, so each one reflects the inputs sampled on the previous edge. The asynchronous active-low reset is released through an internal two-stage synchronizer.

Top module: `tnw_assembler`

## Requirements
- R1: While reset is active, and after it is released, `word_out` is 0, `word_vld` is 0 and `word_held` is 0, and no first nibble is pending. The first word can only be completed after a sync-low cycle.
- R2: In normal mode with gain mode low, a cycle with sync low stores the bus as the pending first nibble. A later cycle with sync high completes the word. `word_vld` is 1 in the cycle after that sync-high cycle, and the pending nibble is then consumed.
- R3: With `cfg_ls_first` = 0, the first nibble goes to `word_out[11:6]` and the second nibble goes to `word_out[5:0]`.
- R4: With `cfg_ls_first` = 1, sampled in the completing cycle, the first nibble goes to `word_out[5:0]` and the second nibble goes to `word_out[11:6]`.
- R5: With `cfg_bypass` = 1 and gain mode low, every cycle yields a word regardless of sync. That word is `{bus, 6'b000000}`, `word_vld` is 1 in the next cycle, and any pending first nibble is discarded.
- R6: Each sync-low cycle that follows another sync-low cycle replaces the pending nibble with the newer value, so the most recent one wins. The word on `word_out` stays unchanged. If a word has been completed since reset, `word_held` is 1 in the next cycle. `word_held` and `word_vld` are never both 1.
- R7: While `gain_mode` is 1, no bus value is forwarded. The cycle produces neither `word_vld` nor `word_held`, and any pending first nibble is discarded.
- R8: A sync-high cycle in normal mode with no pending first nibble is ignored. `word_vld` stays 0 and `word_out` is unchanged.
- R9: `word_vld` is a single-cycle pulse for each new word. `word_out` changes only in cycles in which `word_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bus | input | 6 | Transmit nibble bus |
| tx_sync | input | 1 | Word half marker: low = first nibble, high = second nibble |
| cfg_ls_first | input | 1 | First nibble goes to the low half when 1 |
| cfg_bypass | input | 1 | Reduced-resolution mode, one bus value per word |
| gain_mode | input | 1 | Bus carries gain data; blocks forwarding when 1 |
| word_out | output | 12 | Assembled sample word |
| word_vld | output | 1 | One-cycle pulse when a new word appears |
| word_held | output | 1 | Pulse marking a repeated word slot during a sync stall |

## Verification
The embedded properties check several rules on every cycle. `word_out` stays stable whenever `word_vld` is low. The valid and held flags never coincide. Gain-mode, orphan sync-high and bypass cycles each have the required next-cycle effect. A completing cycle always clears the pending nibble, and a stall after a finished word always raises the held flag.

Only the scoreboard scenarios can show that the bits land in the right place. Those scenarios cover the nibble order in both settings, the latest-wins rule during a stall, the missing held flag before the first word, and the discarding of a pending nibble across gain-mode and bypass cycles. They compare against a model built from the requirements.

// File: rtl/tnw_pkg.sv
package tnw_pkg;
  // Classification of one sampled cycle; drives both storage stages.
  typedef enum logic [2:0] {
    CYC_FIRST   = 3'd0,  // sync low, normal mode: store first nibble
    CYC_SECOND  = 3'd1,  // sync high with nibble pending: finish word
    CYC_ORPHAN  = 3'd2,  // sync high, nothing pending: ignored
    CYC_SINGLE  = 3'd3,  // bypass mode: whole word in one transfer
    CYC_BLOCKED = 3'd4   // gain data on bus: nothing forwarded
  } cyc_kind_e;
endpackage

// File: rtl/tnw_rst_sync.sv
module tnw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) shift_q <= '0;
    else            shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = shift_q[STAGES-1];
endmodule

// File: rtl/tnw_classify.sv
module tnw_classify
  import tnw_pkg::*;
(
  input  logic      sync_i,
  input  logic      bypass_i,
  input  logic      gain_i,
  input  logic      pend_vld_i,
  output cyc_kind_e kind_o
);
  always_comb begin
    if (gain_i)          kind_o = CYC_BLOCKED;
    else if (bypass_i)   kind_o = CYC_SINGLE;
    else if (!sync_i)    kind_o = CYC_FIRST;
    else if (pend_vld_i) kind_o = CYC_SECOND;
    else                 kind_o = CYC_ORPHAN;
  end
endmodule

// File: rtl/tnw_nibble_hold.sv
module tnw_nibble_hold
  import tnw_pkg::*;
#(
  parameter int NIB_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cyc_kind_e        kind_i,
  input  logic [NIB_W-1:0] bus_i,
  output logic [NIB_W-1:0] pend_o,
  output logic             pend_vld_o
);
  logic [NIB_W-1:0] pend_d, pend_q;
  logic             vld_d, vld_q;
  logic             pend_en;

  always_comb begin
    pend_en = (kind_i == CYC_FIRST);
    pend_d  = pend_en ? bus_i : pend_q;
    vld_d   = pend_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign pend_o     = pend_q;
  assign pend_vld_o = vld_q;

  p_pend_consumed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_SECOND) |=> !pend_vld_o);
  p_pend_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_BLOCKED) |=> !pend_vld_o);
  p_pend_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_SINGLE) |=> !pend_vld_o);
endmodule

// File: rtl/tnw_word_reg.sv
module tnw_word_reg
  import tnw_pkg::*;
#(
  parameter int NIB_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cyc_kind_e          kind_i,
  input  logic [NIB_W-1:0]   bus_i,
  input  logic [NIB_W-1:0]   pend_i,
  input  logic               pend_vld_i,
  input  logic               ls_first_i,
  output logic [2*NIB_W-1:0] word_o,
  output logic               vld_o,
  output logic               held_o
);
  localparam int WORD_W = 2 * NIB_W;

  logic [WORD_W-1:0] word_d, word_q;
  logic              word_en;
  logic              vld_d, vld_q;
  logic              held_d, held_q;
  logic              have_d, have_q;

  always_comb begin
    word_en = 1'b0;
    word_d  = word_q;
    unique case (kind_i)
      CYC_SECOND: begin
        word_en = 1'b1;
        word_d  = ls_first_i ? {bus_i, pend_i} : {pend_i, bus_i};
      end
      CYC_SINGLE: begin
        word_en = 1'b1;
        word_d  = {bus_i, {NIB_W{1'b0}}};
      end
      default: ;
    endcase
    vld_d  = word_en;
    have_d = have_q | word_en;
    held_d = (kind_i == CYC_FIRST) & pend_vld_i & have_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
      held_q <= 1'b0;
      have_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      held_q <= held_d;
      have_q <= have_d;
      if (word_en) word_q <= word_d;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;
  assign held_o = held_q;

  p_word_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> $stable(word_o));
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_o && held_o));
  p_bypass_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_SINGLE) |=> (vld_o && word_o[NIB_W-1:0] == '0));
  p_orphan_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_ORPHAN) |=> (!vld_o && $stable(word_o)));
  p_gain_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_BLOCKED) |=> (!vld_o && !held_o));
  p_stall_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_FIRST && pend_vld_i && have_q) |=> held_o);
  p_complete_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_SECOND) |=> vld_o);
endmodule

// File: rtl/tnw_assembler.sv
module tnw_assembler
  import tnw_pkg::*;
#(
  parameter int NIB_W      = 6,
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NIB_W-1:0]   tx_bus,
  input  logic               tx_sync,
  input  logic               cfg_ls_first,
  input  logic               cfg_bypass,
  input  logic               gain_mode,
  output logic [2*NIB_W-1:0] word_out,
  output logic               word_vld,
  output logic               word_held
);
  logic             rst_n_q;
  cyc_kind_e        kind;
  logic [NIB_W-1:0] pend;
  logic             pend_vld;

  tnw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_q)
  );

  tnw_classify u_cls (
    .sync_i     (tx_sync),
    .bypass_i   (cfg_bypass),
    .gain_i     (gain_mode),
    .pend_vld_i (pend_vld),
    .kind_o     (kind)
  );

  tnw_nibble_hold #(.NIB_W(NIB_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n_q),
    .kind_i     (kind),
    .bus_i      (tx_bus),
    .pend_o     (pend),
    .pend_vld_o (pend_vld)
  );

  tnw_word_reg #(.NIB_W(NIB_W)) u_word (
    .clk        (clk),
    .rst_n      (rst_n_q),
    .kind_i     (kind),
    .bus_i      (tx_bus),
    .pend_i     (pend),
    .pend_vld_i (pend_vld),
    .ls_first_i (cfg_ls_first),
    .word_o     (word_out),
    .vld_o      (word_vld),
    .held_o     (word_held)
  );

  p_orphan_port_r8: assert property (@(posedge clk) disable iff (!rst_n_q)
    (tx_sync && !cfg_bypass && !gain_mode && !pend_vld) |=> !word_vld);
  p_gain_port_r7: assert property (@(posedge clk) disable iff (!rst_n_q)
    gain_mode |=> !word_vld);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n_q |-> (!word_vld && !word_held && word_out == '0));
endmodule

// File: tb/tb_tnw_assembler.sv
`timescale 1ns/1ps
module tb_tnw_assembler;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  tx_bus;
  logic        tx_sync, cfg_ls_first, cfg_bypass, gain_mode;
  logic [11:0] word_out;
  logic        word_vld, word_held;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;

  logic [13:0] q_exp[$];
  string       q_tag[$];

  // reference model state
  logic       m_pv;
  logic [5:0] m_pn;
  logic [11:0] m_word;
  logic       m_have;

  always #4 clk = ~clk;

  tnw_assembler dut (
    .clk(clk), .rst_n(rst_n), .tx_bus(tx_bus), .tx_sync(tx_sync),
    .cfg_ls_first(cfg_ls_first), .cfg_bypass(cfg_bypass), .gain_mode(gain_mode),
    .word_out(word_out), .word_vld(word_vld), .word_held(word_held)
  );

  task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual vld=%b held=%b word=%h expected vld=%b held=%b word=%h",
               tag, act[13], act[12], act[11:0], exp[13], exp[12], exp[11:0]);
    end
  endtask

  task automatic drive(input logic [5:0] b, input logic s, input logic ls,
                       input logic byp, input logic g, input string tag);
    logic ev, eh;
    @(negedge clk);
    tx_bus = b; tx_sync = s; cfg_ls_first = ls; cfg_bypass = byp; gain_mode = g;
    ev = 1'b0; eh = 1'b0;
    if (g) m_pv = 1'b0;
    else if (byp) begin
      m_word = {b, 6'b0}; ev = 1'b1; m_have = 1'b1; m_pv = 1'b0;
    end else if (!s) begin
      if (m_pv && m_have) eh = 1'b1;
      m_pn = b; m_pv = 1'b1;
    end else if (m_pv) begin
      m_word = ls ? {b, m_pn} : {m_pn, b};
      ev = 1'b1; m_have = 1'b1; m_pv = 1'b0;
    end
    q_exp.push_back({ev, eh, m_word});
    q_tag.push_back(tag);
  endtask

  // monitor: compares each expected item one clock after its stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        logic [13:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(t, {word_vld, word_held, word_out}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tx_bus = '0; tx_sync = 1'b1; cfg_ls_first = 1'b0; cfg_bypass = 1'b0; gain_mode = 1'b0;
    m_pv = 1'b0; m_pn = '0; m_word = '0; m_have = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset state", {word_vld, word_held, word_out}, 14'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {word_vld, word_held, word_out}, 14'h0);

    drive(6'h3F, 1, 0, 0, 0, "R1 R8 sync high before any first nibble");
    drive(6'h01, 0, 0, 0, 0, "R6 stall before first word, no held");
    drive(6'h2A, 0, 0, 0, 0, "R6 stall before first word, no held");
    drive(6'h15, 1, 0, 0, 0, "R2 R3 pair completes, msb first");
    drive(6'h07, 0, 0, 0, 0, "R2 first nibble");
    drive(6'h38, 1, 1, 0, 0, "R4 ls-first order");
    drive(6'h11, 0, 0, 0, 0, "R6 first low");
    drive(6'h22, 0, 0, 0, 0, "R6 held repeat");
    drive(6'h33, 0, 0, 0, 0, "R6 held repeat latest wins");
    drive(6'h0C, 1, 0, 0, 0, "R6 stall ends with newest nibble");
    drive(6'h3F, 1, 0, 0, 0, "R8 orphan after completion");
    drive(6'h10, 0, 0, 0, 0, "R7 pending before gain");
    drive(6'h12, 0, 0, 0, 1, "R7 gain low-sync blocked");
    drive(6'h13, 1, 0, 0, 0, "R7 pending discarded by gain");
    drive(6'h14, 1, 0, 0, 1, "R7 gain high-sync blocked");
    drive(6'h25, 0, 0, 1, 0, "R5 bypass sync low");
    drive(6'h1A, 1, 1, 1, 0, "R5 bypass sync high");
    drive(6'h09, 0, 0, 0, 0, "R5 pending before bypass");
    drive(6'h31, 1, 0, 1, 0, "R5 bypass word");
    drive(6'h2F, 1, 0, 0, 0, "R5 pending discarded by bypass");
    drive(6'h05, 0, 0, 1, 1, "R7 gain overrides bypass");
    for (int i = 0; i < 16; i++) begin
      drive(6'((i * 5) & 63), 0, 0, 0, 0, "R2 sweep first");
      drive(6'((i * 11 + 3) & 63), 1, i[0], 0, 0, "R3 R4 R9 sweep complete");
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule